// File: doc/BRIEF.md
# CAN Bus Error Detector

This block sits beside the bit-level frame controller of a CAN node. It compares the level the node drives onto the bus with the level sampled back at each bit time. It also looks at phase flags that the controller supplies, and it reports which kind of bus fault has occurred. During the arbitration field, a disagreement between the driven and the sampled level means that another node has won the bus. That case is reported as lost arbitration, not as a fault. Once arbitration is over, the same disagreement is a bit error.

Alongside the per-bit classification, the block counts consecutive dominant samples. When that run reaches a programmable limit, it raises a sticky flag. The flag points to a receive line that is held low, for example by shorted wires. The controller or firmware clears the flag explicitly. Dominant is logic 0 and recessive is logic 1 throughout.

The frame controller asserts `bit_stb` for one clock per bit time, with all phase flags valid in that clock. It reacts to the pulses that appear one clock later.

Top module: `can_err_detect`

## Requirements
- R1: When `bit_stb` is high, `tx_active` is high and `arb_phase` is high, a difference between `tx_bit` and `rx_bit` raises `arb_lost` and never `bit_err`.
- R2: When `bit_stb`, `tx_active` and `!arb_phase` are high and `ack_slot` is low, a difference between `tx_bit` and `rx_bit` raises `bit_err`.
- R3: When `bit_stb` and `fixed_form` are high and `rx_bit` is 0 (dominant), `form_err` is raised, whether or not the node transmits.
- R4: When `bit_stb`, `ack_slot` and `tx_active` are high and `rx_bit` is 1 (recessive), `ack_err` is raised. A dominant acknowledge is never a bit error.
- R5: When `bit_stb` and `crc_check` are high and `crc_match` is low, `crc_err` is raised.
- R6: `stuck_dom` sets once `stuck_limit` consecutive strobed samples have been dominant. A recessive sample restarts the run. A limit of 0 disables the flag.
- R7: `stuck_dom` stays set until `stuck_clr`. `stuck_clr` takes priority over a setting sample and restarts the run.
- R8: Every pulse (`bit_err`, `form_err`, `ack_err`, `crc_err`, `arb_lost`) is high exactly in the clock after the strobe that caused it. No pulse appears without a strobe.
- R9: `err_code` is valid in the same clock as the pulses: 1 for bit, 2 for form, 3 for acknowledge, 4 for CRC. When several faults occur, it shows the lowest of these values. It is 0 when no fault pulse is high, including on lost arbitration.
- R10: With `tx_active` low, no `bit_err`, `arb_lost` or `ack_err` is raised.
- R11: After reset, all pulses, `err_code` and `stuck_dom` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_stb | input | 1 | One-clock strobe at the bit sample point |
| tx_bit | input | 1 | Level the node drives this bit |
| rx_bit | input | 1 | Level sampled from the bus this bit |
| tx_active | input | 1 | Node is transmitting the current frame |
| arb_phase | input | 1 | Bit belongs to the arbitration field |
| fixed_form | input | 1 | Bit is a delimiter or end-of-frame position |
| ack_slot | input | 1 | Bit is the acknowledge slot |
| crc_check | input | 1 | CRC comparison result is valid this bit |
| crc_match | input | 1 | Local and received CRC agree |
| stuck_limit | input | CNT_W | Dominant run length that sets `stuck_dom` (0 disables) |
| stuck_clr | input | 1 | Clears `stuck_dom` and the run counter |
| bit_err | output | 1 | Bit error pulse |
| form_err | output | 1 | Form error pulse |
| ack_err | output | 1 | Acknowledge error pulse |
| crc_err | output | 1 | CRC error pulse |
| arb_lost | output | 1 | Arbitration lost pulse |
| stuck_dom | output | 1 | Sticky stuck-dominant flag |
| err_code | output | 3 | Fault type code accompanying the pulses |

## Verification
The bench aims at the boundary between the arbitration field and the rest of the frame. A design that confuses the two reports lost arbitration as a bit error, or the reverse. A dominant acknowledge from a transmitter is also exercised: a detector that does not exclude the acknowledge slot flags it as a bit error. The bench drives cases where two faults coincide, to catch a wrong code priority. It drives runs of dominant samples that stop one short of the limit, reach the limit, are broken by a recessive bit, use a zero limit, or meet a clear. A counter that is off by one, never restarts, or lets go of the sticky flag fails these cases.

// File: rtl/can_errdet_pkg.sv
// Shared definitions for the CAN error detector.
// Assumes dominant = 0 and recessive = 1 on both tx and rx.
package can_errdet_pkg;
    localparam int CODE_W = 3;
    localparam logic DOMINANT  = 1'b0;
    localparam logic RECESSIVE = 1'b1;

    typedef enum logic [CODE_W-1:0] {
        ERR_NONE = 3'd0,
        ERR_BIT  = 3'd1,
        ERR_FORM = 3'd2,
        ERR_ACK  = 3'd3,
        ERR_CRC  = 3'd4
    } err_code_e;
endpackage

// File: rtl/can_bit_cmp.sv
// Compares driven and sampled levels at each strobe.
// Inside arbitration a mismatch is reported as lost arbitration; after it,
// as a bit error. The acknowledge slot is excluded, because a transmitter
// sends recessive there and expects dominant.
// Assumes inputs are valid in the strobe clock; outputs are registered.
module can_bit_cmp (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_stb,
    input  logic tx_bit,
    input  logic rx_bit,
    input  logic tx_active,
    input  logic arb_phase,
    input  logic ack_slot,
    output logic bit_err,
    output logic arb_lost
);
    logic mismatch;

    // Detect a difference only while this node drives the bus
    always_comb mismatch = bit_stb && tx_active && (tx_bit != rx_bit);

    // Register the classified result as one-clock pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_err  <= 1'b0;
            arb_lost <= 1'b0;
        end else begin
            arb_lost <= mismatch && arb_phase;
            bit_err  <= mismatch && !arb_phase && !ack_slot;
        end
    end

    p_arb_not_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |-> !bit_err);
    p_arb_from_arb_r1: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |-> $past(arb_phase && bit_stb));
    p_bit_needs_stb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_err |-> $past(bit_stb));
    p_bit_needs_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bit_err |-> $past(tx_active));
endmodule

// File: rtl/can_frame_chk.sv
// Frame-position checks: a dominant level at a fixed-form position, a
// missing acknowledge while transmitting, and a failed CRC comparison.
// Assumes the phase flags come from the frame controller and are valid in
// the strobe clock. Outputs are registered one-clock pulses.
module can_frame_chk
    import can_errdet_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_stb,
    input  logic rx_bit,
    input  logic tx_active,
    input  logic fixed_form,
    input  logic ack_slot,
    input  logic crc_check,
    input  logic crc_match,
    output logic form_err,
    output logic ack_err,
    output logic crc_err
);
    logic form_hit, ack_hit, crc_hit;

    // Classify the current bit against its frame position
    always_comb begin
        form_hit = bit_stb && fixed_form && (rx_bit == DOMINANT);
        ack_hit  = bit_stb && ack_slot && tx_active && (rx_bit == RECESSIVE);
        crc_hit  = bit_stb && crc_check && !crc_match;
    end

    // Register the hits as pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            form_err <= 1'b0;
            ack_err  <= 1'b0;
            crc_err  <= 1'b0;
        end else begin
            form_err <= form_hit;
            ack_err  <= ack_hit;
            crc_err  <= crc_hit;
        end
    end

    p_form_dominant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        form_err |-> $past(rx_bit == DOMINANT));
    p_ack_recessive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_err |-> $past(rx_bit == RECESSIVE && tx_active));
    p_crc_needs_stb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err |-> $past(bit_stb && !crc_match));
endmodule

// File: rtl/can_stuck_mon.sv
// Counts consecutive dominant samples. When the run reaches a limit, it
// sets a sticky flag. A limit of zero disables the flag. The counter
// saturates. A clear drops the flag, restarts the run and wins over a set
// in the same clock.
module can_stuck_mon
    import can_errdet_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_stb,
    input  logic             rx_bit,
    input  logic [CNT_W-1:0] stuck_limit,
    input  logic             stuck_clr,
    output logic             stuck_dom
);
    localparam logic [CNT_W-1:0] RUN_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] run_q, run_nxt;
    logic             reach;

    // Next run length: grow on dominant (saturating), restart on recessive
    always_comb begin
        if (rx_bit == DOMINANT)
            run_nxt = (run_q == RUN_MAX) ? run_q : run_q + 1'b1;
        else
            run_nxt = '0;
        reach = (stuck_limit != '0) && (run_nxt >= stuck_limit);
    end

    // Update the run counter and the sticky flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q     <= '0;
            stuck_dom <= 1'b0;
        end else if (stuck_clr) begin
            run_q     <= '0;
            stuck_dom <= 1'b0;
        end else if (bit_stb) begin
            run_q <= run_nxt;
            if (reach) stuck_dom <= 1'b1;
        end
    end

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stuck_dom && !stuck_clr |=> stuck_dom);
    p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stuck_clr |=> !stuck_dom);
    p_set_on_dom_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stuck_dom) |-> $past(bit_stb && rx_bit == DOMINANT));
endmodule

// File: rtl/can_err_detect.sv
// Top of the CAN error detector. Ties together the level comparator, the
// frame-position checks and the stuck-dominant monitor, and derives the
// prioritised fault code from the registered pulses.
// Assumes bit_stb is a single-clock strobe at the bit sample point.
module can_err_detect
    import can_errdet_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_stb,
    input  logic             tx_bit,
    input  logic             rx_bit,
    input  logic             tx_active,
    input  logic             arb_phase,
    input  logic             fixed_form,
    input  logic             ack_slot,
    input  logic             crc_check,
    input  logic             crc_match,
    input  logic [CNT_W-1:0] stuck_limit,
    input  logic             stuck_clr,
    output logic             bit_err,
    output logic             form_err,
    output logic             ack_err,
    output logic             crc_err,
    output logic             arb_lost,
    output logic             stuck_dom,
    output logic [2:0]       err_code
);
    err_code_e code;

    can_bit_cmp u_bit (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .tx_bit(tx_bit),
        .rx_bit(rx_bit), .tx_active(tx_active), .arb_phase(arb_phase),
        .ack_slot(ack_slot), .bit_err(bit_err), .arb_lost(arb_lost)
    );

    can_frame_chk u_frame (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .rx_bit(rx_bit),
        .tx_active(tx_active), .fixed_form(fixed_form), .ack_slot(ack_slot),
        .crc_check(crc_check), .crc_match(crc_match),
        .form_err(form_err), .ack_err(ack_err), .crc_err(crc_err)
    );

    can_stuck_mon #(.CNT_W(CNT_W)) u_stuck (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .rx_bit(rx_bit),
        .stuck_limit(stuck_limit), .stuck_clr(stuck_clr), .stuck_dom(stuck_dom)
    );

    // Priority encode the registered pulses: bit, form, ack, crc
    always_comb begin
        if (bit_err)       code = ERR_BIT;
        else if (form_err) code = ERR_FORM;
        else if (ack_err)  code = ERR_ACK;
        else if (crc_err)  code = ERR_CRC;
        else               code = ERR_NONE;
        err_code = code;
    end

    p_arb_code_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_lost && !form_err && !crc_err) |-> err_code == 3'd0);
    p_bit_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bit_err |-> err_code == 3'd1);
    p_one_clk_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (form_err || ack_err || crc_err || arb_lost) |-> $past(bit_stb));
endmodule

// File: tb/can_err_detect_tb.sv
module can_err_detect_tb;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_stb = 0, tx_bit = 1, rx_bit = 1, tx_active = 0, arb_phase = 0;
    logic fixed_form = 0, ack_slot = 0, crc_check = 0, crc_match = 1;
    logic [CNT_W-1:0] stuck_limit = '0;
    logic stuck_clr = 0;
    logic bit_err, form_err, ack_err, crc_err, arb_lost, stuck_dom;
    logic [2:0] err_code;

    always #4 clk = ~clk;  // 125 MHz

    can_err_detect #(.CNT_W(CNT_W)) u_dut (.*);

    typedef struct packed {
        logic b, f, a, c, l, s;
        logic [2:0] code;
    } exp_t;

    exp_t q[$];
    int checks = 0, fails = 0;
    int run = 0;
    logic flag = 0;
    bit done = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Driver: apply one strobed bit and push the expected result
    task automatic send(input logic ta, input logic ar, input logic ff, input logic ak,
                        input logic cc, input logic cm, input logic tx, input logic rx);
        exp_t e;
        @(negedge clk);
        tx_active = ta; arb_phase = ar; fixed_form = ff; ack_slot = ak;
        crc_check = cc; crc_match = cm; tx_bit = tx; rx_bit = rx; bit_stb = 1;
        e.l = ta && ar && (tx != rx);                 // R1
        e.b = ta && !ar && !ak && (tx != rx);         // R2, R10
        e.f = ff && !rx;                              // R3
        e.a = ak && ta && rx;                         // R4
        e.c = cc && !cm;                              // R5
        if (!rx) run = (run == 255) ? run : run + 1; else run = 0;  // R6
        if (stuck_limit != 0 && run >= stuck_limit) flag = 1;
        e.s = flag;
        e.code = e.b ? 3'd1 : e.f ? 3'd2 : e.a ? 3'd3 : e.c ? 3'd4 : 3'd0;  // R9
        q.push_back(e);
        @(negedge clk);
        bit_stb = 0;
    endtask

    task automatic clear_stuck();
        @(negedge clk);
        stuck_clr = 1;
        @(negedge clk);
        stuck_clr = 0;
        run = 0; flag = 0;   // R7
    endtask

    // Monitor: compare outputs one clock after each strobe; idle otherwise
    initial begin
        logic pend;
        exp_t e;
        forever begin
            @(posedge clk);
            pend = bit_stb;
            @(negedge clk);
            #1;
            if (!rst_n) continue;
            if (pend) begin
                e = q.pop_front();
                chk("R2 bit_err", bit_err, e.b);
                chk("R3 form_err", form_err, e.f);
                chk("R4 ack_err", ack_err, e.a);
                chk("R5 crc_err", crc_err, e.c);
                chk("R1 arb_lost", arb_lost, e.l);
                chk("R6 stuck_dom", stuck_dom, e.s);
                chk("R9 err_code", err_code, e.code);
            end else begin
                chk("R8 no pulse without strobe",
                    {bit_err, form_err, ack_err, crc_err, arb_lost, err_code}, 0);
            end
        end
    end

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11 reset pulses", {bit_err, form_err, ack_err, crc_err, arb_lost}, 0);
        chk("R11 reset code", err_code, 0);
        chk("R11 reset stuck", stuck_dom, 0);
        rst_n = 1;
        stuck_limit = 8'd4;
        //    ta ar ff ak cc cm tx rx
        send(1, 1, 0, 0, 0, 1, 1, 0);  // R1 arbitration lost
        send(1, 1, 0, 0, 0, 1, 0, 0);  // arbitration match
        send(1, 0, 0, 0, 0, 1, 1, 0);  // R2 bit error
        send(1, 0, 0, 0, 0, 1, 0, 1);  // R2 bit error, opposite polarity
        send(0, 0, 1, 0, 0, 1, 1, 0);  // R3 form error as receiver
        send(0, 0, 1, 0, 0, 1, 1, 1);  // recessive delimiter
        send(1, 0, 0, 1, 0, 1, 1, 1);  // R4 missing acknowledge
        send(1, 0, 0, 1, 0, 1, 1, 0);  // R4 acknowledged, no bit error
        send(0, 0, 0, 0, 1, 0, 1, 1);  // R5 crc error
        send(0, 0, 0, 0, 1, 1, 1, 1);  // crc match
        send(0, 0, 0, 0, 0, 1, 1, 0);  // R10 mismatch as receiver
        send(1, 0, 1, 0, 0, 1, 1, 0);  // R9 bit + form -> code 1
        send(0, 0, 1, 0, 1, 0, 1, 0);  // R9 form + crc -> code 2, run 3
        send(0, 0, 0, 0, 0, 1, 1, 0);  // R6 fourth dominant sets flag
        send(0, 0, 0, 0, 0, 1, 1, 1);  // R7 flag holds
        clear_stuck();
        send(0, 0, 0, 0, 0, 1, 1, 0);  // R7 cleared, run 1
        stuck_limit = 8'd0;
        for (int i = 0; i < 10; i++) send(0, 0, 0, 0, 0, 1, 1, 0);  // R6 limit 0 disables
        stuck_limit = 8'd2;
        send(0, 0, 0, 0, 0, 1, 1, 0);  // R6 sets at new limit
        clear_stuck();
        send(0, 0, 0, 0, 0, 1, 1, 0);  // run 1
        send(0, 0, 0, 0, 0, 1, 1, 1);  // R6 recessive restarts run
        send(0, 0, 0, 0, 0, 1, 1, 0);  // run 1, no flag
        send(0, 0, 0, 0, 0, 1, 1, 0);  // run 2, flag
        repeat (3) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule